// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Down-Counter

This block is a 16-bit programmable interrupt counter that a CPU controls through four write-only registers. Software loads the count one byte at a time, then arms the counter. Each pulse on the per-scanline strobe takes a fixed step of 123 off the count while it is armed. When a step brings the count to zero or below, the block raises a level interrupt request, disarms itself and reloads the count to 0xFFFF.

Any write to one of the four registers also acknowledges a pending request. The request line stays high until such a write arrives or reset is applied. A write to the block's registers takes precedence over a scanline step that lands in the same cycle. The scanline strobe source and the CPU's interrupt controller are outside this block.

Top module: `scnirq_top`

## Requirements
- R1: After reset, irq is low, the counter is disarmed and the count is 0, so arming and then giving one scanline strobe raises irq.
- R2: A write to 0xF001 (address bits [1:0] = 01) arms the counter. A write to 0xF000 (bits [1:0] = 00) disarms it.
- R3: A write to 0xF002 replaces count bits [7:0] and a write to 0xF003 replaces count bits [15:8]. Each keeps the other byte.
- R4: Each scanline strobe that arrives while the counter is armed lowers the count by 123.
- R5: irq rises on the clock edge that takes a strobe whose step leaves the count at zero or below. A count of 123 fires on the first strobe and a count of 124 fires on the second.
- R6: When irq fires, the counter disarms itself and the count becomes 0xFFFF. Arming again without a reload therefore takes 533 strobes to fire.
- R7: Once high, irq stays high across further strobes and across writes to other addresses. It falls on the edge after a write to any of 0xF000 to 0xF003, or on reset.
- R8: A scanline strobe while the counter is disarmed leaves the count unchanged.
- R9: When a write to 0xF000 to 0xF003 and a scanline strobe occur in the same cycle, the write is applied and the strobe is dropped.
- R10: A write to any address outside 0xF000 to 0xF003 has no effect on the counter, on arming or on irq. A strobe in the same cycle as such a write is still counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | Per-scanline strobe, one cycle per scanline |
| irq | output | 1 | Active-high interrupt request (level) |

## Verification
The bench probes the firing threshold at counts of exactly 123 and 124. A design that tested only for a negative result, or tested strictly below zero, would be one strobe late on the first of these. It re-arms after a firing with no reload and expects 533 strobes; a design that kept the residue or reloaded to zero would give a different count. Byte loads are checked by replacing one byte of a loaded value, which catches a load that clears the other byte. Same-cycle collisions check that a register write suppresses the strobe, which an update in the wrong order would let fire early. They also check that a write to an unrelated address neither clears irq nor blocks the strobe.

// File: rtl/scnirq_pkg.sv
package scnirq_pkg;

   // Register operation selected by the low two address bits.
   typedef enum logic [1:0] {
      OP_DISARM  = 2'd0,
      OP_ARM     = 2'd1,
      OP_LOAD_LO = 2'd2,
      OP_LOAD_HI = 2'd3
   } op_e;

   // Decoded CPU command, valid when hit is set.
   typedef struct packed {
      logic hit;
      op_e  op;
   } cmd_t;

endpackage

// File: rtl/scnirq_decode.sv
module scnirq_decode
   import scnirq_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'hF000
)(
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output cmd_t              cmd
);

   localparam int unsigned SEL_W = 2;

   // The window is aligned to four registers.
   if (REG_BASE[SEL_W-1:0] != '0) begin : g_bad_base
      $error("REG_BASE must be aligned to a four-register window");
   end

   logic in_window;

   always_comb begin
      in_window = (wr_addr[ADDR_W-1:SEL_W] == REG_BASE[ADDR_W-1:SEL_W]);
      cmd.hit   = wr_en && in_window;
      cmd.op    = op_e'(wr_addr[SEL_W-1:0]);
   end

endmodule

// File: rtl/scnirq_core.sv
module scnirq_core
   import scnirq_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STEP   = 123
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_tick,
   output logic              armed,
   output logic              fire,
   output logic [CNT_W-1:0]  cnt
);

   localparam int unsigned      LANES  = CNT_W / DATA_W;
   localparam logic [CNT_W:0]   STEP_X = (CNT_W+1)'(STEP);
   localparam logic [CNT_W-1:0] STEP_U = CNT_W'(STEP);
   localparam logic [CNT_W-1:0] RELOAD = '1;

   if (LANES != 2 || (LANES * DATA_W) != CNT_W) begin : g_bad_lanes
      $error("CNT_W must be exactly two data bytes wide");
   end
   if (STEP == 0 || STEP >= (2 ** CNT_W)) begin : g_bad_step
      $error("STEP must be non-zero and fit in CNT_W bits");
   end

   logic [CNT_W-1:0] load_val;
   logic [CNT_W:0]   diff;     // one extra bit holds the sign of the result
   logic             spent;
   logic             step_ok;

   // Byte lanes: lane i is written by operation OP_LOAD_LO + i.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic lane_we;
      always_comb begin
         lane_we = cmd.hit && (cmd.op == op_e'(int'(OP_LOAD_LO) + i));
         load_val[i*DATA_W +: DATA_W] = lane_we ? wr_data
                                                : cnt[i*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      diff    = {1'b0, cnt} - STEP_X;
      spent   = diff[CNT_W] || (diff == '0);
      step_ok = line_tick && armed && !cmd.hit;
      fire    = step_ok && spent;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (cmd.hit) begin
         cnt <= load_val;
         case (cmd.op)
            OP_DISARM: armed <= 1'b0;
            OP_ARM:    armed <= 1'b1;
            default:   armed <= armed;
         endcase
      end else if (step_ok) begin
         if (spent) begin
            cnt   <= RELOAD;
            armed <= 1'b0;
         end else begin
            cnt <= diff[CNT_W-1:0];
         end
      end
   end

   AST_ARM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.hit && cmd.op == OP_ARM) |=> armed); // R2
   AST_DISARM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.hit && cmd.op == OP_DISARM) |=> !armed); // R2
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && armed && !cmd.hit && !fire) |=> (cnt == $past(cnt) - STEP_U)); // R4
   AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == RELOAD && !armed)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && !armed && !cmd.hit) |=> $stable(cnt)); // R8
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_tick && !cmd.hit) |=> ($stable(cnt) && $stable(armed))); // R10

endmodule

// File: rtl/scnirq_flag.sv
module scnirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   input  logic fire,
   output logic irq
);

   always_ff @(posedge clk) begin
      if (!rst_n)    irq <= 1'b0;
      else if (ack)  irq <= 1'b0;
      else if (fire) irq <= 1'b1;
   end

   AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> irq); // R5
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq); // R7
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq); // R7
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fire)); // R5

endmodule

// File: rtl/scnirq_top.sv
module scnirq_top
   import scnirq_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 16,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       CNT_W    = 16,
   parameter int unsigned       STEP     = 123,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'hF000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_tick,
   output logic              irq
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end

   cmd_t             cmd;
   logic             armed;
   logic             fire;
   logic [CNT_W-1:0] cnt;

   scnirq_decode #(
      .ADDR_W   (ADDR_W),
      .REG_BASE (REG_BASE)
   ) u_decode (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .cmd     (cmd)
   );

   scnirq_core #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .STEP   (STEP)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .wr_data   (wr_data),
      .line_tick (line_tick),
      .armed     (armed),
      .fire      (fire),
      .cnt       (cnt)
   );

   scnirq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .ack   (cmd.hit),
      .fire  (fire),
      .irq   (irq)
   );

   AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !armed); // R6
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.hit && line_tick) |=> !irq); // R9
   AST_RESET_STATE: assert property (@(posedge clk)
      $past(!rst_n) |-> (!irq && !armed && cnt == '0)); // R1

endmodule

// File: tb/tb_scnirq_top.sv
module tb_scnirq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        line_tick = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;   // 125 MHz

   scnirq_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .line_tick (line_tick),
      .irq       (irq)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One-cycle stimulus; on return the edge has been taken and outputs settled.
   task automatic cycle(input logic we, input logic [15:0] a,
                        input logic [7:0] d, input logic tk);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; line_tick = tk;
      @(negedge clk);
      wr_en = 1'b0; line_tick = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      cycle(1'b1, a, d, 1'b0);
   endtask

   task automatic tick();
      cycle(1'b0, 16'h0000, 8'h00, 1'b1);
   endtask

   task automatic load(input int v);
      wr(16'hF002, v[7:0]);
      wr(16'hF003, v[15:8]);
   endtask

   // Strobes until irq rises; returns the count or -1.
   task automatic ticks_to_fire(input int max, output int n);
      n = 0;
      while (!irq && n < max) begin
         tick();
         n++;
      end
      if (!irq) n = -1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      int n;
      do_reset();
      check("R1 irq low after reset", irq, 0);
      tick();
      check("R1 disarmed after reset", irq, 0);
      wr(16'hF001, 8'h00);
      ticks_to_fire(10, n);
      check("R1 zero count fires on first strobe", n, 1);
   endtask

   task automatic t_threshold();
      int n;
      wr(16'hF000, 8'h00);
      load(123);
      wr(16'hF001, 8'h00);
      ticks_to_fire(10, n);
      check("R5 count 123 fires on strobe 1", n, 1);
      wr(16'hF000, 8'h00);
      check("R2 disarm write clears irq", irq, 0);
      load(124);
      wr(16'hF001, 8'h00);
      tick();
      check("R4 count 124 survives one strobe", irq, 0);
      tick();
      check("R5 count 124 fires on strobe 2", irq, 1);
   endtask

   task automatic t_bytes();
      int n;
      wr(16'hF000, 8'h00);
      load(16'h01F6);               // 502 -> 5 strobes
      wr(16'hF001, 8'h00);
      ticks_to_fire(20, n);
      check("R3 R4 count 0x01F6 strobes", n, 5);
      load(16'h01F6);
      wr(16'hF003, 8'h02);          // 0x02F6 = 758 -> 7 strobes
      wr(16'hF001, 8'h00);
      ticks_to_fire(20, n);
      check("R3 high byte keeps low byte", n, 7);
      load(16'h0300);
      wr(16'hF002, 8'h0F);          // 0x030F = 783 -> 7 strobes
      wr(16'hF001, 8'h00);
      ticks_to_fire(20, n);
      check("R3 low byte keeps high byte", n, 7);
   endtask

   task automatic t_reload();
      int n;
      // irq is high from the previous task; counter disarmed, count 0xFFFF
      tick();
      tick();
      check("R6 self-disarm keeps irq, no re-fire", irq, 1);
      wr(16'hF001, 8'h00);
      check("R2 arm write clears irq", irq, 0);
      ticks_to_fire(1000, n);
      check("R6 reload 0xFFFF takes 533 strobes", n, 533);
   endtask

   task automatic t_sticky();
      wr(16'hE003, 8'h55);
      check("R7 R10 unrelated write keeps irq", irq, 1);
      tick();
      check("R7 irq held over strobes", irq, 1);
      wr(16'hF003, 8'h00);
      check("R7 load write clears irq", irq, 0);
      load(123);
      wr(16'hF001, 8'h00);
      tick();
      check("R7 re-fire", irq, 1);
      do_reset();
      check("R7 reset clears irq", irq, 0);
   endtask

   task automatic t_disarmed();
      int n;
      load(246);
      for (int i = 0; i < 10; i++) tick();
      check("R8 no irq while disarmed", irq, 0);
      wr(16'hF001, 8'h00);
      ticks_to_fire(20, n);
      check("R8 count unchanged while disarmed", n, 2);
      wr(16'hF000, 8'h00);
      load(246);
      wr(16'hF001, 8'h00);
      tick();
      wr(16'hF000, 8'h00);
      tick();
      tick();
      wr(16'hF001, 8'h00);
      ticks_to_fire(20, n);
      check("R2 R8 disarm freezes partial count", n, 1);
   endtask

   task automatic t_priority();
      int n;
      wr(16'hF000, 8'h00);
      load(123);
      wr(16'hF001, 8'h00);
      cycle(1'b1, 16'hF001, 8'h00, 1'b1);
      check("R9 strobe dropped under write", irq, 0);
      ticks_to_fire(10, n);
      check("R9 count intact after collision", n, 1);
      wr(16'hF000, 8'h00);
      load(123);
      wr(16'hF001, 8'h00);
      cycle(1'b1, 16'h8000, 8'hFF, 1'b1);
      check("R10 strobe counted beside unrelated write", irq, 1);
      load(200);
      wr(16'hF001, 8'h00);
      wr(16'hC002, 8'h00);
      wr(16'hF00A, 8'h00);
      ticks_to_fire(10, n);
      check("R10 unrelated writes leave count", n, 2);
   endtask

   initial begin
      t_reset();
      t_threshold();
      t_bytes();
      t_reload();
      t_sticky();
      t_disarmed();
      t_priority();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule